// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzle Unit

This block rewrites bit 6 of a byte address so that accesses to a tiled surface land on the memory channel that the graphics engine expects when memory is interleaved across two channels. Bit 6 of the address is XORed with a set of higher address bits. Which bits are used depends on two things: the orientation of the tile, and how the memory is configured. An X-tiled surface uses bits 9 and 10. A Y-tiled surface uses bit 9. When the processor-side channel randomization is active, bit 11 or bit 17 is added to either set. Linear surfaces pass through unchanged.

Each transfer carries its own inputs: an address, a tiling mode, a raw memory configuration word, and a detection select with two rank-boundary values. The unit decodes the swizzle mode from these and applies it to the address. It returns the rewritten address and a 3-bit code for the mode it chose. An error flag marks a configuration that cannot be read. Transfers use a valid/ready handshake and pass through a single output register. The output register is refilled in the same cycle that it is drained. The address width must be at least 7 bits. Source bits at or above the address width are left out of the XOR.

Top module: `bit6_swizzle_unit`

## Requirements
- R1: `inReady` is high whenever `outValid` is low or `outReady` is high. A transfer accepted on a rising edge is presented with `outValid` high after that edge. While `outValid` is high and `outReady` is low, `outValid`, `outAddr`, `outMode` and `outErr` stay unchanged.
- R2: Tiling mode 0 (linear) and tiling mode 3 (reserved) give mode code 0 (none) and an unchanged address, for any configuration word and for either detection path. Tiling mode 1 is X and tiling mode 2 is Y.
- R3: With `detectSel`=0 and the configuration word not all ones, channel field `cfgWord[1:0]` values 0 (single), 1 (asymmetric dual) and 3 (reserved) give mode code 0 and an unchanged address.
- R4: With channel field 2 (interleaved) and the XOR-disable flag `cfgWord[2]` set, X gives code 2 (bits 9,10) and Y gives code 1 (bit 9).
- R5: With channel field 2, `cfgWord[2]`=0 and the select flag `cfgWord[3]`=0, X gives code 4 (bits 9,10,11) and Y gives code 3 (bits 9,11).
- R6: With channel field 2, `cfgWord[2]`=0 and `cfgWord[3]`=1, X gives code 6 (bits 9,10,17) and Y gives code 5 (bits 9,17).
- R7: With `detectSel`=0, a configuration word of all ones on an X or Y transfer gives code 7 (unknown), an unchanged address, and `outErr`=1. `outErr` is 0 for every other code.
- R8: With `detectSel`=1, the configuration word is ignored. Equal rank boundaries give X code 2 and Y code 1. Different rank boundaries give code 0.
- R9: Only bit 6 of the address can change. Output bit 6 equals input bit 6 XORed with each source bit named by the chosen mode.
- R10: When `outValid` and `outReady` are both high, a new transfer can be accepted on the same edge. A stream of transfers is then accepted one per cycle, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request carries a transfer |
| inReady | output | 1 | Unit can take a transfer this cycle |
| inAddr | input | ADDR_W | Byte address to translate |
| inTile | input | 2 | Tiling mode: 0 linear, 1 X, 2 Y, 3 reserved |
| cfgWord | input | CFG_W | Memory configuration: [1:0] channel mode, [2] XOR disable, [3] bit-17 select |
| detectSel | input | 1 | 1 selects detection by rank-boundary comparison |
| rankBoundA | input | RANK_W | Rank boundary of channel A |
| rankBoundB | input | RANK_W | Rank boundary of channel B |
| outValid | output | 1 | Result is presented |
| outReady | input | 1 | Consumer takes the result |
| outAddr | output | ADDR_W | Swizzled address |
| outMode | output | 3 | Swizzle mode code chosen (0..7 as in R2 to R8) |
| outErr | output | 1 | Configuration unreadable (mode unknown) |

## Verification
Two functions can fall in the same cycle: handing a result to the consumer and capturing the next transfer into the same output register. The bench provokes this in two ways. First, it streams transfers back to back while `outReady` is held high. Second, it lets `outReady` wander in a pseudo-random pattern. A scoreboard queue checks that every accepted transfer comes out once and in order, with the address and mode code computed from the requirements. Cycle counts of the acceptances confirm one transfer per cycle. A hold monitor confirms that a stalled result never moves.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swzMode_e;

  typedef enum logic [1:0] {
    TILE_LINEAR = 2'd0,
    TILE_X      = 2'd1,
    TILE_Y      = 2'd2,
    TILE_RSVD   = 2'd3
  } tileMode_e;

  typedef enum logic [1:0] {
    CH_SINGLE      = 2'd0,
    CH_ASYM        = 2'd1,
    CH_INTERLEAVED = 2'd2,
    CH_RSVD        = 2'd3
  } chanMode_e;

  // configuration field positions
  localparam int unsigned CFG_CHAN_LSB = 0;
  localparam int unsigned CFG_XOR_OFF  = 2;
  localparam int unsigned CFG_SEL17    = 3;

  // bit that is rewritten, and the candidate XOR sources
  localparam int unsigned TARGET_BIT = 6;
  localparam int unsigned NUM_TERMS  = 4;
  localparam int unsigned SRC_POS [NUM_TERMS] = '{9, 10, 11, 17};

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    swzMode_e mode;
  } swzStrobe_t;

  // term mask: bit0 -> 9, bit1 -> 10, bit2 -> 11, bit3 -> 17
  function automatic logic [NUM_TERMS-1:0] termMask(swzMode_e m);
    logic [NUM_TERMS-1:0] k;
    case (m)
      SWZ_9:       k = 4'b0001;
      SWZ_9_10:    k = 4'b0011;
      SWZ_9_11:    k = 4'b0101;
      SWZ_9_10_11: k = 4'b0111;
      SWZ_9_17:    k = 4'b1001;
      SWZ_9_10_17: k = 4'b1011;
      default:     k = 4'b0000;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int RANK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inTile,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              detectSel,
  input  logic [RANK_W-1:0] rankBoundA,
  input  logic [RANK_W-1:0] rankBoundB,
  output logic              outValid,
  input  logic              outReady,
  output swzStrobe_t        strobe
);

  logic      validQ;
  logic      accept;
  swzMode_e  xMode;
  swzMode_e  yMode;
  swzMode_e  pickMode;
  chanMode_e chanMode;
  logic      cfgBad;
  logic      ranksEq;

  assign inReady  = !validQ || outReady;
  assign accept   = inValid && inReady;
  assign outValid = validQ;

  assign chanMode = chanMode_e'(cfgWord[CFG_CHAN_LSB +: 2]);
  assign cfgBad   = &cfgWord;
  assign ranksEq  = (rankBoundA == rankBoundB);

  // per-orientation decode of the configuration
  always_comb begin
    xMode = SWZ_NONE;
    yMode = SWZ_NONE;
    if (detectSel) begin
      if (ranksEq) begin
        xMode = SWZ_9_10;
        yMode = SWZ_9;
      end
    end else if (cfgBad) begin
      xMode = SWZ_UNKNOWN;
      yMode = SWZ_UNKNOWN;
    end else if (chanMode == CH_INTERLEAVED) begin
      if (cfgWord[CFG_XOR_OFF]) begin
        xMode = SWZ_9_10;
        yMode = SWZ_9;
      end else if (!cfgWord[CFG_SEL17]) begin
        xMode = SWZ_9_10_11;
        yMode = SWZ_9_11;
      end else begin
        xMode = SWZ_9_10_17;
        yMode = SWZ_9_17;
      end
    end
  end

  always_comb begin
    case (tileMode_e'(inTile))
      TILE_X:  pickMode = xMode;
      TILE_Y:  pickMode = yMode;
      default: pickMode = SWZ_NONE;
    endcase
  end

  assign strobe.load = accept;
  assign strobe.mode = pickMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (accept) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  // R1: a stalled result stays presented
  p_hold_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R1: an accepted transfer is presented next cycle
  p_accept_shows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  // R10: a drained result with no new transfer leaves the stage empty
  p_drain_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !inValid |=> !outValid);

endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  swzStrobe_t        strobe,
  input  logic [ADDR_W-1:0] inAddr,
  output logic [ADDR_W-1:0] outAddr,
  output logic [2:0]        outMode,
  output logic              outErr
);

  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << TARGET_BIT);

  logic [NUM_TERMS-1:0] mask;
  logic [NUM_TERMS-1:0] termBit;
  logic                 flip;
  logic [ADDR_W-1:0]    swzAddr;
  logic [ADDR_W-1:0]    addrQ;
  swzMode_e             modeQ;
  logic                 errQ;

  assign mask = termMask(strobe.mode);

  // each source bit takes part only if the address is wide enough
  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
    if (SRC_POS[g] < ADDR_W) begin : g_live
      assign termBit[g] = inAddr[SRC_POS[g]] & mask[g];
    end else begin : g_absent
      assign termBit[g] = 1'b0;
    end
  end

  assign flip = ^termBit;

  always_comb begin
    swzAddr             = inAddr;
    swzAddr[TARGET_BIT] = inAddr[TARGET_BIT] ^ flip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      modeQ <= SWZ_NONE;
      errQ  <= 1'b0;
    end else if (strobe.load) begin
      addrQ <= swzAddr;
      modeQ <= strobe.mode;
      errQ  <= (strobe.mode == SWZ_UNKNOWN);
    end
  end

  assign outAddr = addrQ;
  assign outMode = modeQ;
  assign outErr  = errQ;

  // R1: no load leaves the result untouched
  p_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(outAddr) && $stable(outMode) && $stable(outErr));

  // R9: only the target bit may differ from the accepted address
  p_only_bit6_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ((outAddr ^ $past(inAddr)) & KEEP_MASK) == '0);

  // R7: unknown mode passes the address and raises the error flag
  p_unknown_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.mode == SWZ_UNKNOWN |=> outErr && outAddr == $past(inAddr));

  // R7: error flag stays low for known modes
  p_known_noerr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && strobe.mode != SWZ_UNKNOWN |=> !outErr);

endmodule

// File: rtl/bit6_swizzle_unit.sv
module bit6_swizzle_unit
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32,
  parameter int RANK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [1:0]        inTile,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              detectSel,
  input  logic [RANK_W-1:0] rankBoundA,
  input  logic [RANK_W-1:0] rankBoundB,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic [2:0]        outMode,
  output logic              outErr
);

  swzStrobe_t strobe;

  swz_ctrl #(.CFG_W(CFG_W), .RANK_W(RANK_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inReady    (inReady),
    .inTile     (inTile),
    .cfgWord    (cfgWord),
    .detectSel  (detectSel),
    .rankBoundA (rankBoundA),
    .rankBoundB (rankBoundB),
    .outValid   (outValid),
    .outReady   (outReady),
    .strobe     (strobe)
  );

  swz_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inAddr  (inAddr),
    .outAddr (outAddr),
    .outMode (outMode),
    .outErr  (outErr)
  );

  logic takeIn;
  logic tiled;
  logic cfgOk;
  assign takeIn = inValid && inReady;
  assign tiled  = (inTile == TILE_X) || (inTile == TILE_Y);
  assign cfgOk  = !detectSel && !(&cfgWord);

  // R2: untiled transfers are never swizzled
  p_linear_r2: assert property (@(posedge clk) disable iff (!rstN)
    takeIn && !tiled |=> outMode == SWZ_NONE && outAddr == $past(inAddr));

  // R3: non-interleaved channel modes never swizzle
  p_noninterleaved_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeIn && cfgOk && cfgWord[1:0] != CH_INTERLEAVED |=> outMode == SWZ_NONE);

  // R4: XOR disabled leaves only the base swizzle
  p_base_x_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeIn && cfgOk && cfgWord[1:0] == CH_INTERLEAVED && cfgWord[CFG_XOR_OFF]
      && inTile == TILE_X |=> outMode == SWZ_9_10);

  // R8: the rank comparison path ignores the configuration word
  p_detect_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeIn && detectSel && tiled && rankBoundA != rankBoundB |=> outMode == SWZ_NONE && !outErr);

endmodule

// File: tb/sim_bit6_swizzle_unit.sv
`timescale 1ns/1ps
module sim_bit6_swizzle_unit;
  import swz_pkg::*;

  localparam int ADDR_W = 32;
  localparam int CFG_W  = 32;
  localparam int RANK_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [1:0] inTile = '0;
  logic [CFG_W-1:0] cfgWord = '0;
  logic detectSel = 1'b0;
  logic [RANK_W-1:0] rankBoundA = '0;
  logic [RANK_W-1:0] rankBoundB = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [ADDR_W-1:0] outAddr;
  logic [2:0] outMode;
  logic outErr;

  always #10 clk = ~clk;

  bit6_swizzle_unit #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .RANK_W(RANK_W)) u0 (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bpOn = 1'b0;
  bit done = 1'b0;

  logic [ADDR_W-1:0] expAddrQ[$];
  logic [2:0]        expModeQ[$];
  logic              expErrQ[$];
  string             tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // expected mode from the requirements
  function automatic logic [2:0] refMode(logic [1:0] t, logic [CFG_W-1:0] c, logic d,
                                         logic [RANK_W-1:0] a, logic [RANK_W-1:0] b);
    logic isX;
    if (t == 2'd0 || t == 2'd3) return 3'd0;           // R2
    isX = (t == 2'd1);
    if (d) begin                                       // R8
      if (a == b) return isX ? 3'd2 : 3'd1;
      return 3'd0;
    end
    if (&c) return 3'd7;                               // R7
    if (c[1:0] != 2'd2) return 3'd0;                   // R3
    if (c[2]) return isX ? 3'd2 : 3'd1;                // R4
    if (!c[3]) return isX ? 3'd4 : 3'd3;               // R5
    return isX ? 3'd6 : 3'd5;                          // R6
  endfunction

  // expected address from the requirements (R9)
  function automatic logic [ADDR_W-1:0] refAddr(logic [ADDR_W-1:0] a, logic [2:0] m);
    logic t;
    logic [ADDR_W-1:0] r;
    case (m)
      3'd1: t = a[9];
      3'd2: t = a[9] ^ a[10];
      3'd3: t = a[9] ^ a[11];
      3'd4: t = a[9] ^ a[10] ^ a[11];
      3'd5: t = a[9] ^ a[17];
      3'd6: t = a[9] ^ a[10] ^ a[17];
      default: t = 1'b0;
    endcase
    r = a;
    r[6] = a[6] ^ t;
    return r;
  endfunction

  int lastAccept = 0;

  task automatic send(input logic [ADDR_W-1:0] a, input logic [1:0] t, input logic [CFG_W-1:0] c,
                      input logic d, input logic [RANK_W-1:0] ra, input logic [RANK_W-1:0] rb,
                      input string tag);
    logic rdy;
    logic [2:0] m;
    @(negedge clk);
    #1;
    inAddr = a; inTile = t; cfgWord = c; detectSel = d; rankBoundA = ra; rankBoundB = rb;
    inValid = 1'b1;
    forever begin
      #1;
      rdy = inReady;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
      #1;
    end
    lastAccept = cyc;
    m = refMode(t, c, d, ra, rb);
    expAddrQ.push_back(refAddr(a, m));
    expModeQ.push_back(m);
    expErrQ.push_back(m == 3'd7);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    inValid = 1'b0;
  endtask

  // monitor: drives outReady, pops the scoreboard, and watches stalls
  logic [ADDR_W-1:0] prevAddr;
  logic [2:0] prevMode;
  bit prevStall = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        check(outValid && outAddr == prevAddr && outMode == prevMode,
              "R1 stalled result moved", {outAddr, 29'd0, outMode}, {prevAddr, 29'd0, prevMode});
      end
      outReady = bpOn ? (($urandom % 3) != 0) : 1'b1;
      if (outValid && outReady) begin
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R10 unexpected result", 64'(outAddr), 64'd0);
        end else begin
          logic [ADDR_W-1:0] ea;
          logic [2:0] em;
          logic ee;
          string tg;
          ea = expAddrQ.pop_front();
          em = expModeQ.pop_front();
          ee = expErrQ.pop_front();
          tg = tagQ.pop_front();
          check(outAddr == ea, {tg, " address"}, 64'(outAddr), 64'(ea));
          check(outMode == em, {tg, " mode"}, 64'(outMode), 64'(em));
          check(outErr == ee, {tg, " R7 error flag"}, 64'(outErr), 64'(ee));
        end
      end
      prevStall = outValid && !outReady;
      prevAddr  = outAddr;
      prevMode  = outMode;
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  localparam logic [CFG_W-1:0] CFG_ALL1  = '1;
  localparam logic [CFG_W-1:0] CFG_BASE  = 32'h0000_0006; // interleaved, XOR off
  localparam logic [CFG_W-1:0] CFG_B11   = 32'h0000_0002; // interleaved, bit 11
  localparam logic [CFG_W-1:0] CFG_B17   = 32'h0000_000A; // interleaved, bit 17

  initial begin
    logic [ADDR_W-1:0] pat [6];
    int startCyc;
    pat = '{32'hFFFF_FFFF, 32'h0000_0240, 32'h0002_0000, 32'h0000_0800,
            32'h0000_0400, 32'h1357_9BDF};

    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(outValid == 1'b0, "R1 reset outValid", 64'(outValid), 64'd0);
    check(inReady == 1'b1, "R1 reset inReady", 64'(inReady), 64'd1);
    rstN = 1'b1;

    // R1 latency: present right after acceptance
    send(32'h0000_0200, 2'd1, CFG_BASE, 1'b0, 0, 0, "R4 latency");
    idle();
    #1;
    check(outValid == 1'b1, "R1 presented one cycle after accept", 64'(outValid), 64'd1);

    // R2 linear and reserved tiling, any config
    send(32'hFFFF_FFFF, 2'd0, CFG_B17, 1'b0, 0, 0, "R2 linear");
    send(32'h0000_0E40, 2'd0, CFG_ALL1, 1'b0, 0, 0, "R2 linear unreadable cfg");
    send(32'h0002_0600, 2'd3, CFG_B11, 1'b0, 0, 0, "R2 reserved tile");
    send(32'h0000_0600, 2'd0, CFG_BASE, 1'b1, 5, 5, "R2 linear detect path");

    // R3 non-interleaved channel modes
    send(32'h0002_0E00, 2'd1, 32'h0000_0000, 1'b0, 0, 0, "R3 single X");
    send(32'h0002_0E00, 2'd2, 32'h0000_0009, 1'b0, 0, 0, "R3 asym Y");
    send(32'h0002_0E00, 2'd1, 32'h0000_000B, 1'b0, 0, 0, "R3 reserved X");

    // R4 to R6 with R9 bit patterns
    foreach (pat[i]) begin
      send(pat[i], 2'd1, CFG_BASE, 1'b0, 0, 0, "R4 X base R9");
      send(pat[i], 2'd2, CFG_BASE, 1'b0, 0, 0, "R4 Y base R9");
      send(pat[i], 2'd1, CFG_B11,  1'b0, 0, 0, "R5 X bit11 R9");
      send(pat[i], 2'd2, CFG_B11,  1'b0, 0, 0, "R5 Y bit11 R9");
      send(pat[i], 2'd1, CFG_B17,  1'b0, 0, 0, "R6 X bit17 R9");
      send(pat[i], 2'd2, CFG_B17,  1'b0, 0, 0, "R6 Y bit17 R9");
    end

    // R7 unreadable configuration
    send(32'h0002_0E40, 2'd1, CFG_ALL1, 1'b0, 0, 0, "R7 unknown X");
    send(32'h0002_0E00, 2'd2, CFG_ALL1, 1'b0, 0, 0, "R7 unknown Y");

    // R8 rank comparison path, config ignored
    send(32'h0000_0600, 2'd1, CFG_ALL1, 1'b1, 16'h0040, 16'h0040, "R8 equal X");
    send(32'h0000_0200, 2'd2, CFG_B17,  1'b1, 16'h0040, 16'h0040, "R8 equal Y");
    send(32'h0000_0600, 2'd1, CFG_B11,  1'b1, 16'h0040, 16'h03F0, "R8 differ X");
    send(32'h0002_0200, 2'd2, CFG_ALL1, 1'b1, 16'h0010, 16'h0020, "R8 differ Y");
    idle();

    // R10 back-to-back stream, one per cycle
    repeat (3) @(posedge clk);
    send(32'h0000_0200, 2'd1, CFG_BASE, 1'b0, 0, 0, "R10 stream");
    startCyc = lastAccept;
    for (int k = 1; k < 8; k++) begin
      send(32'h0000_0200 + (k << 9), 2'(1 + (k % 2)), CFG_B11, 1'b0, 0, 0, "R10 stream");
    end
    check(lastAccept - startCyc == 7, "R10 accept cycles for 8 transfers",
          64'(lastAccept - startCyc), 64'd7);
    idle();

    // R1 and R10 under backpressure with mixed inputs
    bpOn = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [CFG_W-1:0] c;
      case ($urandom % 6)
        0: c = CFG_BASE;
        1: c = CFG_B11;
        2: c = CFG_B17;
        3: c = CFG_ALL1;
        4: c = 32'h0000_0001;
        default: c = 32'h0000_0000;
      endcase
      send($urandom, 2'($urandom % 4), c, 1'($urandom % 2),
           16'($urandom % 2), 16'($urandom % 2), "R10 backpressure R1");
    end
    idle();
    bpOn = 1'b0;

    while (expAddrQ.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule